// File: doc/BRIEF.md
# HD Serial Word Scrambler and NRZI Precoder

This block sits in the transmit path of an HD serial digital video link, just ahead of the serializer. On each clock it accepts one 20-bit parallel word. The luma sample is in the upper ten bits and the chroma sample is in the lower ten. The block treats the twenty bits as one serial stream, least significant bit first. That stream passes through a self-synchronizing scrambler with polynomial x^9 + x^4 + 1 and then through an NRZI precoder with polynomial x + 1. The scrambler and precoder state carries from one word to the next, so the output is what a bit-serial coder would produce on the same stream.

A mode input selects pass-through. In that mode the word reaches the output unchanged and both coder stages keep their state. A separate clear input is synchronized to the clock. Its rising edge zeroes the scrambler register and the NRZI bit, so the coder can be restarted at a known point. The output is registered, and the latency is one clock in both modes.

Top module: `hd_scrambler_nrzi`

## Requirements
- R1: While `rst_n` is low, `dout` is all zeros. The first coded word after reset starts from a zero scrambler register and a zero NRZI bit.
- R2: The output is registered with a latency of one clock. When `bypass` is 1 at a rising edge, `dout` after that edge equals the `din` sampled at that edge.
- R3: When `bypass` is 0, bit 0 of the word is the earliest in serial order and bit 19 is the latest. Each scrambled bit is the input bit XOR the scrambled bit from nine positions earlier XOR the scrambled bit from four positions earlier. These positions count back across earlier coded words.
- R4: Each output bit in coding mode is the scrambled bit XOR the previous output bit. For bit 0, the previous output bit is bit 19 of the last coded output word.
- R5: A word passed through with `bypass` = 1 leaves the scrambler register and the NRZI bit unchanged. The next coded word continues from the state left by the last coded word.
- R6: A rising edge on `srst_in` clears the coder state. Count as edge 1 the first rising clock edge that samples `srst_in` high after it was sampled low. The word captured at edge 3 is then coded from a zero scrambler register and a zero NRZI bit.
- R7: Holding `srst_in` high or low causes no further clears. Each low-to-high transition produces exactly one clear.
- R8: A clear that falls on a pass-through word still zeroes the state, so the next coded word starts from zero.
- R9: Luma bits 19:10 follow chroma bits 9:0 in the serial stream. Starting from zero state with an all-zero chroma word, `dout[9:0]` is zero whatever the luma value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parallel word clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| din | input | 20 | Input word: luma in 19:10, chroma in 9:0 |
| bypass | input | 1 | 1 selects pass-through; 0 selects scramble plus NRZI |
| srst_in | input | 1 | Coder clear request, acted on at its rising edge |
| dout | output | 20 | Registered output word |

## Verification
The bench builds the block with its default parameters: two ten-bit lanes, a nine-bit scrambler with a tap at four, and a two-stage clear synchronizer. With these values, a full 20-bit word spans more than two scrambler lengths. Feedback can therefore wrap inside one word and also across a word boundary, and a bit-serial model checks both cases. The two-stage synchronizer places the clear at edge 3. This lets the bench check the clear cycle exactly, and also check clears that coincide with pass-through words or with a held-high request.

// File: rtl/hdsc_pkg.sv
`timescale 1ns/1ps
package hdsc_pkg;
   localparam int unsigned LANE_W_DFLT   = 10;
   localparam int unsigned LANES_DFLT    = 2;
   localparam int unsigned SCR_LEN_DFLT  = 9;
   localparam int unsigned SCR_TAP_DFLT  = 4;
   localparam int unsigned SYNC_N_DFLT   = 2;

   typedef enum logic {
      MODE_CODE = 1'b0,
      MODE_PASS = 1'b1
   } hdsc_mode_e;
endpackage

// File: rtl/hdsc_clr_detect.sv
`timescale 1ns/1ps
module hdsc_clr_detect #(
   parameter int unsigned SYNC_N = hdsc_pkg::SYNC_N_DFLT
) (
   input  logic clk,
   input  logic rst_n,
   input  logic req_async,
   output logic clr_pulse
);
   generate
      if (SYNC_N < 2) begin : g_bad_sync
         $error("hdsc_clr_detect: SYNC_N must be at least 2");
      end
   endgenerate

   logic [SYNC_N-1:0] sync_q;
   logic              seen_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q[0] <= 1'b0;
      else        sync_q[0] <= req_async;
   end

   generate
      for (genvar s = 1; s < SYNC_N; s++) begin : g_sync
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sync_q[s] <= 1'b0;
            else        sync_q[s] <= sync_q[s-1];
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) seen_q <= 1'b0;
      else        seen_q <= sync_q[SYNC_N-1];
   end

   assign clr_pulse = sync_q[SYNC_N-1] & ~seen_q;
endmodule

// File: rtl/hdsc_scr_chain.sv
`timescale 1ns/1ps
module hdsc_scr_chain #(
   parameter int unsigned WORD_W  = 20,
   parameter int unsigned SCR_LEN = hdsc_pkg::SCR_LEN_DFLT,
   parameter int unsigned SCR_TAP = hdsc_pkg::SCR_TAP_DFLT
) (
   input  logic [SCR_LEN-1:0] state_in,
   input  logic [WORD_W-1:0]  word_in,
   output logic [WORD_W-1:0]  word_out,
   output logic [SCR_LEN-1:0] state_out
);
   generate
      if (SCR_TAP == 0 || SCR_TAP >= SCR_LEN) begin : g_bad_tap
         $error("hdsc_scr_chain: SCR_TAP must lie in 1..SCR_LEN-1");
      end
   endgenerate

   // link[k] holds the history register before serial bit k; bit 0 is newest
   logic [WORD_W:0][SCR_LEN-1:0] link;

   assign link[0] = state_in;

   generate
      for (genvar k = 0; k < WORD_W; k++) begin : g_bit
         logic fb;
         assign fb          = word_in[k] ^ link[k][SCR_LEN-1] ^ link[k][SCR_TAP-1];
         assign word_out[k] = fb;
         assign link[k+1]   = {link[k][SCR_LEN-2:0], fb};
      end
   endgenerate

   assign state_out = link[WORD_W];
endmodule

// File: rtl/hdsc_nrzi_chain.sv
`timescale 1ns/1ps
module hdsc_nrzi_chain #(
   parameter int unsigned WORD_W = 20
) (
   input  logic              level_in,
   input  logic [WORD_W-1:0] word_in,
   output logic [WORD_W-1:0] word_out,
   output logic              level_out
);
   logic [WORD_W:0] lvl;

   assign lvl[0] = level_in;

   generate
      for (genvar k = 0; k < WORD_W; k++) begin : g_bit
         assign lvl[k+1]    = lvl[k] ^ word_in[k];
         assign word_out[k] = lvl[k+1];
      end
   endgenerate

   assign level_out = lvl[WORD_W];
endmodule

// File: rtl/hd_scrambler_nrzi.sv
`timescale 1ns/1ps
module hd_scrambler_nrzi #(
   parameter int unsigned LANE_W  = hdsc_pkg::LANE_W_DFLT,
   parameter int unsigned LANES   = hdsc_pkg::LANES_DFLT,
   parameter int unsigned SCR_LEN = hdsc_pkg::SCR_LEN_DFLT,
   parameter int unsigned SCR_TAP = hdsc_pkg::SCR_TAP_DFLT,
   parameter int unsigned SYNC_N  = hdsc_pkg::SYNC_N_DFLT
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [LANE_W*LANES-1:0]   din,
   input  logic                      bypass,
   input  logic                      srst_in,
   output logic [LANE_W*LANES-1:0]   dout
);
   import hdsc_pkg::*;

   localparam int unsigned WORD_W = LANE_W * LANES;

   generate
      if (LANE_W == 0 || LANES == 0) begin : g_bad_word
         $error("hd_scrambler_nrzi: lane width and lane count must be non-zero");
      end
   endgenerate

   hdsc_mode_e          mode;
   logic                clr_pulse;
   logic [SCR_LEN-1:0]  scr_q, scr_eff, scr_nxt;
   logic                lvl_q, lvl_eff, lvl_nxt;
   logic [WORD_W-1:0]   scr_word, code_word, dout_q;

   assign mode = (bypass == 1'b1) ? MODE_PASS : MODE_CODE;

   hdsc_clr_detect #(.SYNC_N(SYNC_N)) u_clr (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_async (srst_in),
      .clr_pulse (clr_pulse)
   );

   // a clear makes the word at this edge start from zero state
   assign scr_eff = clr_pulse ? '0   : scr_q;
   assign lvl_eff = clr_pulse ? 1'b0 : lvl_q;

   hdsc_scr_chain #(
      .WORD_W  (WORD_W),
      .SCR_LEN (SCR_LEN),
      .SCR_TAP (SCR_TAP)
   ) u_scr (
      .state_in  (scr_eff),
      .word_in   (din),
      .word_out  (scr_word),
      .state_out (scr_nxt)
   );

   hdsc_nrzi_chain #(.WORD_W(WORD_W)) u_nrzi (
      .level_in  (lvl_eff),
      .word_in   (scr_word),
      .word_out  (code_word),
      .level_out (lvl_nxt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dout_q <= '0;
         scr_q  <= '0;
         lvl_q  <= 1'b0;
      end else begin
         unique case (mode)
            MODE_CODE: begin
               dout_q <= code_word;
               scr_q  <= scr_nxt;
               lvl_q  <= lvl_nxt;
            end
            MODE_PASS: begin
               dout_q <= din;
               scr_q  <= scr_eff;
               lvl_q  <= lvl_eff;
            end
            default: begin
               dout_q <= din;
            end
         endcase
      end
   end

   assign dout = dout_q;
endmodule

// File: rtl/hd_scrambler_nrzi_chk.sv
`timescale 1ns/1ps
module hd_scrambler_nrzi_chk #(
   parameter int unsigned WORD_W  = 20,
   parameter int unsigned SCR_LEN = 9,
   parameter int unsigned SCR_TAP = 4
) (
   input logic               clk,
   input logic               rst_n,
   input logic [WORD_W-1:0]  din,
   input logic               bypass,
   input logic [WORD_W-1:0]  dout,
   input logic               clr_pulse,
   input logic [SCR_LEN-1:0] scr_q,
   input logic               lvl_q
);
   // history of what the block was asked to do, to descramble dout independently
   logic [WORD_W-1:0] prev_dout, cap_din;
   logic              cap_coded_clean, prev_coded, cap_coded;
   logic [1:0]        age;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_dout       <= '0;
         cap_din         <= '0;
         cap_coded_clean <= 1'b0;
         cap_coded       <= 1'b0;
         prev_coded      <= 1'b0;
         age             <= '0;
      end else begin
         prev_dout       <= dout;
         cap_din         <= din;
         cap_coded_clean <= !bypass && !clr_pulse;
         cap_coded       <= !bypass;
         prev_coded      <= cap_coded;
         if (age != 2'd3) age <= age + 2'd1;
      end
   end

   // undo NRZI then the scrambler, using the previous output word as history
   logic [2*WORD_W-1:0] both;
   logic [2*WORD_W-1:0] unn;
   logic [WORD_W-1:0]   recovered;

   assign both = {dout, prev_dout};

   always_comb begin
      unn = '0;
      for (int k = 1; k < 2*WORD_W; k++) unn[k] = both[k] ^ both[k-1];
      for (int k = 0; k < WORD_W; k++)
         recovered[k] = unn[WORD_W+k] ^ unn[WORD_W+k-SCR_LEN] ^ unn[WORD_W+k-SCR_TAP];
   end

   AST_BYPASS_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      bypass |=> dout == $past(din)); // R2

   AST_PASS_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
      (bypass && !clr_pulse) |=> ($stable(scr_q) && $stable(lvl_q))); // R5

   AST_CLEAR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      clr_pulse |=> !clr_pulse); // R7

   AST_CLEAR_IN_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_pulse && bypass) |=> (scr_q == '0 && lvl_q == 1'b0)); // R8

   AST_SELF_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
      (age >= 2'd2 && cap_coded_clean && prev_coded) |-> recovered == cap_din); // R3
endmodule

bind hd_scrambler_nrzi hd_scrambler_nrzi_chk #(
   .WORD_W  (LANE_W*LANES),
   .SCR_LEN (SCR_LEN),
   .SCR_TAP (SCR_TAP)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .din       (din),
   .bypass    (bypass),
   .dout      (dout),
   .clr_pulse (clr_pulse),
   .scr_q     (scr_q),
   .lvl_q     (lvl_q)
);

// File: tb/hd_scrambler_nrzi_tb_top.sv
`timescale 1ns/1ps
module hd_scrambler_nrzi_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int W = 20;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [W-1:0] din = '0;
   logic         bypass = 1'b0;
   logic         srst_in = 1'b0;
   logic [W-1:0] dout;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   // bench reference state
   logic [8:0]   m_scr;
   logic         m_lvl;
   logic [2:0]   m_hist;   // srst_in samples at the last three edges, [0] newest
   logic [W-1:0] m_exp;

   always #(CLK_PERIOD/2) clk = ~clk;

   hd_scrambler_nrzi dut_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .din     (din),
      .bypass  (bypass),
      .srst_in (srst_in),
      .dout    (dout)
   );

   task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: dout=%05h expected=%05h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic model_reset();
      m_scr  = '0;
      m_lvl  = 1'b0;
      m_hist = '0;
   endtask

   // one word through the bit-serial reference; returns expected dout
   task automatic model_step(input logic [W-1:0] d, input logic byp, input logic rq);
      logic clear_now;
      logic s;
      // R6: clear on edge 3 counting the first edge that samples the request high
      clear_now = m_hist[1] && !m_hist[2];
      m_hist = {m_hist[1:0], rq};
      if (clear_now) begin
         m_scr = '0;
         m_lvl = 1'b0;
      end
      if (byp) begin
         m_exp = d;
      end else begin
         for (int k = 0; k < W; k++) begin
            s = d[k] ^ m_scr[8] ^ m_scr[3];
            m_scr = {m_scr[7:0], s};
            m_lvl = m_lvl ^ s;
            m_exp[k] = m_lvl;
         end
      end
   endtask

   task automatic step(input logic [W-1:0] d, input logic byp, input logic rq, input string req);
      @(negedge clk);
      din = d; bypass = byp; srst_in = rq;
      @(posedge clk);
      model_step(d, byp, rq);
      #1;
      check(req, dout, m_exp);
   endtask

   initial begin : watchdog
      #(CLK_PERIOD * 200000);
      if (!done) begin
         n_fail++; n_chk++;
         $display("FAIL watchdog expired");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin : stim
      logic [W-1:0] r;
      logic         rq;
      void'($urandom(32'h5EED_0A17));
      model_reset();
      m_exp = '0;
      repeat (3) @(posedge clk);
      #1;
      check("R1 reset", dout, '0);
      @(negedge clk);
      rst_n = 1'b1;

      // R1/R3: from zero state a zero word codes to zero; single bits
      step(20'h00000, 1'b0, 1'b0, "R1 zero state");
      step(20'h00001, 1'b0, 1'b0, "R3 lsb first");
      step(20'h80000, 1'b0, 1'b0, "R4 carry across words");
      step(20'hFFFFF, 1'b0, 1'b0, "R3 all ones");
      step(20'h00000, 1'b0, 1'b0, "R4 zero after ones");

      // R2/R5: pass-through words, then resume coding
      step(20'h3FC00, 1'b1, 1'b0, "R2 pass luma");
      step(20'h003FF, 1'b1, 1'b0, "R2 pass chroma");
      step(20'h12345, 1'b0, 1'b0, "R5 resume after pass");

      // R6: clear on edge 3, zero word there codes to zero
      step(20'hABCDE, 1'b0, 1'b1, "R6 edge1");
      step(20'h5A5A5, 1'b0, 1'b1, "R6 edge2");
      step(20'h00000, 1'b0, 1'b1, "R6 edge3");
      check("R6 cleared zero word", dout, '0);

      // R9: luma-only word after clear leaves chroma output zero
      step(20'h00000, 1'b0, 1'b0, "R9 prep");
      step(20'h00000, 1'b0, 1'b1, "R9 edge1");
      step(20'h00000, 1'b0, 1'b1, "R9 edge2");
      step(20'hB5C00, 1'b0, 1'b1, "R9 luma only");
      check("R9 chroma half zero", {10'h0, dout[9:0]}, '0);

      // R7: request held high, no further clear
      for (int i = 0; i < 30; i++) step(20'(($urandom)), 1'b0, 1'b1, "R7 held high");
      for (int i = 0; i < 10; i++) step(20'(($urandom)), 1'b0, 1'b0, "R7 held low");

      // R8: clear on a pass-through word
      step(20'h77777, 1'b0, 1'b1, "R8 edge1");
      step(20'h11111, 1'b1, 1'b1, "R8 edge2");
      step(20'h22222, 1'b1, 1'b0, "R8 edge3 pass");
      step(20'h00000, 1'b0, 1'b0, "R8 zero word after clear");
      check("R8 state zero", dout, '0);

      // random mix
      rq = 1'b0;
      for (int i = 0; i < 600; i++) begin
         r = 20'($urandom);
         if (($urandom % 23) == 0) rq = ~rq;
         step(r, (($urandom % 8) == 0), rq, "R3/R4/R5 random");
      end

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule